// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that holds a small bank of control registers for an audio power stage. A bus master opens a transaction with a START, sends the 7-bit device address with a direction bit, and then sends data bytes. Each written byte carries its own register select in its upper bits, so a single write transaction can update several registers, one byte each. The register contents leave the block as parallel control outputs.

The upper three bits of a byte pick one of seven 5-bit registers. The code 111 opens a second group of four 2-bit registers, and bits 4:2 then pick one of them. For a read, the master first writes the byte that selects a register. It then issues a repeated START and the read address. The slave returns the selected register as a whole byte, in the same layout that would write it. SCL and SDA arrive already synchronised to `clk`. The slave acts on SDA only through a pull-down enable, and SDA is expected to be an open-drain line with an external pull-up.

Top module: `ctrl_i2c_slave`

## Requirements
- R1: After reset every register is zero, `dev_enable_o` is 0 and `sda_pull_o` is 0.
- R2: The slave acknowledges only the address 7'b1111100 (bytes 0xF8 for write, 0xF9 for read) by pulling SDA low during the ninth clock. For any other address it does not acknowledge, and it ignores the rest of the transaction up to the next START or STOP.
- R3: In a write transaction, every data byte is acknowledged by a low SDA in its ninth clock.
- R4: A written byte with B7:B5 in 000..110 stores B4:B0 into `main_reg_o[B7:B5]`.
- R5: A written byte with B7:B5 = 111 stores B1:B0 into a sub-register chosen by B4:B2: 000 gives `sub_reg_o[0]`, 010 gives index 1, 100 gives index 2, and 110 or 111 gives index 3.
- R6: A byte with B7:B5 = 111 and B4:B2 of 001, 011 or 101 is acknowledged. It changes no register and does not change the read selection.
- R7: After a repeated START and address 0xF9, the slave sends the most recently selected register MSB first. A main register is sent as {index, value}. A sub-register is sent as {111, index shifted left by one bit, value}. SDA changes only while SCL is low.
- R8: When the master acknowledges a read byte, the same register is sent again. When the master does not acknowledge, the slave releases SDA and stays released until the next START.
- R9: A STOP at any point, including in the middle of a byte, releases SDA and ends the transaction. A partly received byte changes nothing.
- R10: `dev_enable_o` follows bit 0 of main register 0.
- R11: Several data bytes in one write transaction each update their own register, in the order they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (line level) |
| sda_pull_o | output | 1 | 1 drives SDA low |
| main_reg_o | output | 7x5 | Main registers, index = select code |
| sub_reg_o | output | 4x2 | Sub-registers under code 111 |
| dev_enable_o | output | 1 | Global device enable |

## Verification
The decoder is tried with every main prefix and with every sub-code, including both encodings that map to index 3, so that a wrong bit slice or a missing alias gives a different output. The undefined sub-codes are written and then read back. This shows that they leave both the registers and the read selection as they were. Wrong addresses, a read that the master acknowledges and then does not acknowledge, and a STOP in the middle of a byte separate the acknowledge, release and abort paths from the normal write path.

// File: rtl/ctrl_i2c_pkg.sv
package ctrl_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAIN_N  = 7;
  localparam int MAIN_W  = 5;
  localparam int SUB_N   = 4;
  localparam int SUB_W   = 2;
  localparam int CNT_W   = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_AACK, LK_WDATA, LK_WACK, LK_RDATA, LK_RACK, LK_SKIP
  } link_st_e;

  typedef struct packed {
    logic       hit;
    logic       sub;
    logic [2:0] idx;
  } sel_t;

  // Prefix decode: 3-bit main code, or 111 followed by a 3-bit sub code.
  function automatic sel_t decode_byte(input logic [BYTE_W-1:0] b);
    sel_t s;
    s.hit = 1'b1;
    s.sub = 1'b0;
    s.idx = b[7:5];
    if (b[7:5] == 3'b111) begin
      s.sub = 1'b1;
      case (b[4:2])
        3'b000:         s.idx = 3'd0;
        3'b010:         s.idx = 3'd1;
        3'b100:         s.idx = 3'd2;
        3'b110, 3'b111: s.idx = 3'd3;
        default: begin
          s.idx = 3'd0;
          s.hit = 1'b0;
        end
      endcase
    end
    return s;
  endfunction

  function automatic logic [2:0] sub_code(input logic [1:0] idx);
    return {idx, 1'b0};
  endfunction
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  =  scl_i & ~scl_q;
  assign scl_fall  = ~scl_i &  scl_q;
  assign start_det =  scl_i &  scl_q &  sda_q & ~sda_i;
  assign stop_det  =  scl_i &  scl_q & ~sda_q &  sda_i;
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import ctrl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_i,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);
  link_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              full, rw, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; cnt <= '0; sh <= '0; tx <= '0;
      full <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      sda_pull <= 1'b0; wr_stb <= 1'b0; wr_byte <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_det) begin
        st <= LK_ADDR; cnt <= '0; full <= 1'b0; sda_pull <= 1'b0;
      end else if (stop_det) begin
        st <= LK_IDLE; full <= 1'b0; sda_pull <= 1'b0;
      end else begin
        case (st)
          LK_ADDR, LK_WDATA: begin
            if (scl_rise && !full) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
              if (cnt == CNT_W'(BYTE_W-1)) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (st == LK_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1; rw <= sh[0]; st <= LK_AACK;
                end else begin
                  st <= LK_SKIP;
                end
              end else begin
                sda_pull <= 1'b1; wr_stb <= 1'b1; wr_byte <= sh; st <= LK_WACK;
              end
            end
          end
          LK_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_byte; sda_pull <= ~rd_byte[BYTE_W-1]; st <= LK_RDATA;
            end else begin
              sda_pull <= 1'b0; st <= LK_WDATA;
            end
          end
          LK_WACK: if (scl_fall) begin
            sda_pull <= 1'b0; st <= LK_WDATA;
          end
          LK_RDATA: if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BYTE_W-1)) begin
              sda_pull <= 1'b0; st <= LK_RACK;
            end else begin
              tx <= {tx[BYTE_W-2:0], 1'b0}; sda_pull <= ~tx[BYTE_W-2];
            end
          end
          LK_RACK: begin
            if (scl_rise) mack <= ~sda_i;
            else if (scl_fall) begin
              if (mack) begin
                tx <= rd_byte; sda_pull <= ~rd_byte[BYTE_W-1]; st <= LK_RDATA;
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_ADDR && scl_fall && full && sh[7:1] == DEV_ADDR) |=> sda_pull);
  p_data_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_WDATA && scl_fall && full) |=> (sda_pull && wr_stb));
  p_stb_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_sda_low_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));
  p_nack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_RACK && scl_fall && !mack && !start_det) |=> (!sda_pull && st == LK_IDLE));
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import ctrl_i2c_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_stb,
  input  logic [BYTE_W-1:0]             wr_byte,
  output logic [MAIN_N-1:0][MAIN_W-1:0] main_q,
  output logic [SUB_N-1:0][SUB_W-1:0]   sub_q,
  output logic [BYTE_W-1:0]             rd_byte
);
  sel_t dec;
  logic sel_sub;
  logic [2:0] sel_idx;

  assign dec = decode_byte(wr_byte);

  for (genvar g = 0; g < MAIN_N; g++) begin : g_main
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) main_q[g] <= '0;
      else if (wr_stb && dec.hit && !dec.sub && dec.idx == 3'(g))
        main_q[g] <= wr_byte[MAIN_W-1:0];
    end
  end

  for (genvar g = 0; g < SUB_N; g++) begin : g_sub
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sub_q[g] <= '0;
      else if (wr_stb && dec.hit && dec.sub && dec.idx == 3'(g))
        sub_q[g] <= wr_byte[SUB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sub <= 1'b0; sel_idx <= '0;
    end else if (wr_stb && dec.hit) begin
      sel_sub <= dec.sub; sel_idx <= dec.idx;
    end
  end

  always_comb begin
    if (sel_sub) rd_byte = {3'b111, sub_code(sel_idx[1:0]), sub_q[sel_idx[1:0]]};
    else         rd_byte = {sel_idx, main_q[sel_idx]};
  end

  p_undef_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !dec.hit) |=> ($stable(main_q) && $stable(sub_q) && $stable(rd_byte)));
  p_main_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_byte[7:5] == 3'b000) |=> main_q[0] == $past(wr_byte[MAIN_W-1:0]));
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(main_q) && $stable(sub_q)));
endmodule

// File: rtl/ctrl_i2c_slave.sv
module ctrl_i2c_slave
  import ctrl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1111100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_pull_o,
  output logic [MAIN_N-1:0][MAIN_W-1:0] main_reg_o,
  output logic [SUB_N-1:0][SUB_W-1:0]   sub_reg_o,
  output logic                          dev_enable_o
);
  logic scl_rise, scl_fall, start_det, stop_det, wr_stb;
  logic [BYTE_W-1:0] wr_byte, rd_byte;

  i2c_line_mon u_mon (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_rise, .scl_fall, .start_det, .stop_det
  );

  i2c_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk, .rst_n, .sda_i, .scl_rise, .scl_fall, .start_det, .stop_det,
    .rd_byte, .sda_pull(sda_pull_o), .wr_stb, .wr_byte
  );

  ctrl_reg_bank u_bank (
    .clk, .rst_n, .wr_stb, .wr_byte,
    .main_q(main_reg_o), .sub_q(sub_reg_o), .rd_byte
  );

  assign dev_enable_o = main_reg_o[0][0];

  p_enable_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_enable_o) |-> $past(wr_stb && wr_byte[7:5] == 3'b000));
endmodule

// File: tb/sim_ctrl_i2c_slave.sv
module sim_ctrl_i2c_slave;
  localparam int Q = 5;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_pull, dev_en, sda_line;
  logic [6:0][4:0] main_r;
  logic [3:0][1:0] sub_r;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int    exp_q[$];
  int    act_q[$];
  string req_q[$];

  always #5 clk = ~clk;
  assign sda_line = sda_drv & ~sda_pull;

  ctrl_i2c_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .main_reg_o(main_r), .sub_reg_o(sub_r),
    .dev_enable_o(dev_en)
  );

  // scoreboard monitor
  initial forever begin
    wait (act_q.size() > 0);
    begin
      int e, a; string r;
      e = exp_q.pop_front(); a = act_q.pop_front(); r = req_q.pop_front();
      n_cmp++;
      if (e != a) begin
        n_bad++;
        $display("FAIL %s actual=0x%0h expected=0x%0h", r, a, e);
      end
    end
  end

  task automatic expect_v(string req, int e);
    req_q.push_back(req); exp_q.push_back(e);
  endtask
  task automatic observe(int a);
    act_q.push_back(a);
  endtask
  task automatic chk(string req, int e, int a);
    expect_v(req, e); observe(a);
  endtask

  task automatic tick(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start();
    sda_drv = 1; tick(); scl = 1; tick(); sda_drv = 0; tick(); scl = 0; tick();
  endtask
  task automatic i2c_stop();
    sda_drv = 0; tick(); scl = 1; tick(); sda_drv = 1; tick();
  endtask
  task automatic wbit(logic b);
    sda_drv = b; tick(); scl = 1; tick(); scl = 0; tick();
  endtask
  task automatic send(string req, logic [7:0] b, logic exp_ack_line);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    expect_v(req, exp_ack_line);
    sda_drv = 1; tick(); scl = 1; tick(); observe(sda_line); scl = 0; tick();
  endtask
  task automatic recv(string req, int e, logic m_ack);
    logic [7:0] v;
    expect_v(req, e);
    sda_drv = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(); scl = 1; tick(); v[i] = sda_line; scl = 0;
    end
    tick(); observe(v);
    sda_drv = ~m_ack; tick(); scl = 1; tick(); scl = 0; tick(); sda_drv = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 main", 0, main_r); chk("R1 sub", 0, sub_r);
    chk("R1 pull", 0, sda_pull); chk("R1 enable", 0, dev_en);
    // R3 R4 R11 multi-byte write
    i2c_start(); send("R2 addr ack", 8'hF8, 0);
    send("R3 ack b0", 8'h01, 0); send("R3 ack b1", 8'h3A, 0); send("R3 ack b2", 8'hC7, 0);
    i2c_stop(); tick();
    chk("R4 main0", 5'h01, main_r[0]); chk("R11 main1", 5'h1A, main_r[1]);
    chk("R4 main6", 5'h07, main_r[6]); chk("R10 enable", 1, dev_en);
    // R5 sub-registers, both codes for index 3
    i2c_start(); send("R2 addr", 8'hF8, 0);
    send("R5 s0", 8'hE3, 0); send("R5 s1", 8'hEA, 0); send("R5 s2", 8'hF1, 0);
    send("R5 s3a", 8'hFA, 0); send("R5 s3b", 8'hFD, 0);
    i2c_stop(); tick();
    chk("R5 sub0", 3, sub_r[0]); chk("R5 sub1", 2, sub_r[1]);
    chk("R5 sub2", 1, sub_r[2]); chk("R5 sub3", 1, sub_r[3]);
    // R6 undefined codes
    i2c_start(); send("R2 addr", 8'hF8, 0);
    send("R6 ack 001", 8'hE7, 0); send("R6 ack 011", 8'hEF, 0); send("R6 ack 101", 8'hF7, 0);
    i2c_stop(); tick();
    chk("R6 sub kept", 8'b01_01_10_11, sub_r); chk("R6 main1 kept", 5'h1A, main_r[1]);
    // R6 R7 selection unchanged by undefined code; sub read layout
    i2c_start(); send("R2 addr", 8'hF8, 0); send("R6 ack", 8'hE7, 0);
    i2c_start(); send("R2 read addr", 8'hF9, 0);
    recv("R6 R7 sub readback", 8'hF9, 0);
    i2c_stop(); tick();
    // R7 R8 main read, ACK then NACK
    i2c_start(); send("R2 addr", 8'hF8, 0); send("R3 ack", 8'hA9, 0);
    i2c_start(); send("R2 read addr", 8'hF9, 0);
    recv("R7 read", 8'hA9, 1); recv("R8 repeat", 8'hA9, 0);
    sda_drv = 1; tick(); scl = 1; tick(); chk("R8 released", 1, sda_line); scl = 0; tick();
    i2c_stop(); tick();
    chk("R4 main5", 9, main_r[5]);
    // R2 wrong addresses
    i2c_start(); send("R2 nack 0x90", 8'h90, 1); send("R2 ignored", 8'h00, 1); i2c_stop(); tick();
    i2c_start(); send("R2 nack 0xFA", 8'hFA, 1); send("R2 ignored", 8'h00, 1); i2c_stop(); tick();
    chk("R2 main0 kept", 1, main_r[0]);
    // R9 stop inside a byte
    i2c_start(); send("R2 addr", 8'hF8, 0); send("R3 ack", 8'h41, 0);
    wbit(0); wbit(1); wbit(0); wbit(0);
    i2c_stop(); tick();
    chk("R9 pull", 0, sda_pull); chk("R9 main2", 1, main_r[2]); chk("R9 main1", 5'h1A, main_r[1]);
    // R10 disable
    i2c_start(); send("R2 addr", 8'hF8, 0); send("R3 ack", 8'h00, 0); i2c_stop(); tick();
    chk("R10 disabled", 0, dev_en);
    wait (act_q.size() == 0); tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule